// File: doc/BRIEF.md
# Sixteen-Way Sticky Round-Robin Arbiter

This block shares one resource among sixteen clients. Each client lowers its own request line to ask for the resource, and it sees its own grant line go low when it owns it. Once a client holds the grant, it keeps it for as long as its request stays low. The grant passes on only when that client lets go, or when an external active-low strobe forces a fresh decision. A fresh decision scans the clients in rotating order. The scan begins one position past the previous winner, so no client can starve the others.

The work is split into two phases, and each phase is an enable on a single clock. In a phase-B cycle the block decides who owns the resource. In a phase-A cycle it turns the recorded owner into the registered grant outputs. When both enables are high in the same cycle, the outputs show the owner as it was before that cycle's decision. The new owner appears on the next phase-A cycle.

Top module: `rr16_arbiter`

## Requirements
- R1: While rst is high at a clock edge, all grant outputs go high (1), the owner is set to none and the scan start is set to client 0. The first decision after reset with every request low therefore picks client 0.
- R2: Grant outputs change only on a clock edge where ph_a_en is high. On such an edge, gnt_n[i] becomes 0 exactly for the recorded owner i and 1 for every other bit. All bits become 1 when there is no owner.
- R3: At most one bit of gnt_n is 0 at any time.
- R4: On a clock edge where ph_b_en is high, a new decision is made in three cases: force_n is 0; the owner's request bit is 1; or there is no owner and at least one request bit is 0. In every other case the owner is kept, which makes the grant sticky.
- R5: A decision checks clients start, start+1, and so on, wrapping modulo 16. It picks the first client whose req_n bit is 0. Bit i of req_n and gnt_n belongs to client i.
- R6: After a decision picks client w, the scan start becomes (w+1) mod 16.
- R7: A decision that finds no request bit at 0 sets the owner to none and leaves the scan start unchanged.
- R8: On an edge where ph_b_en is low, the owner and the scan start do not change, whatever req_n and force_n do.
- R9: When ph_a_en and ph_b_en are high on the same edge, the grant outputs reflect the owner from before that edge's decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ph_a_en | input | 1 | Phase-A enable: load the grant outputs from the owner |
| ph_b_en | input | 1 | Phase-B enable: make the arbitration decision |
| force_n | input | 1 | Active-low strobe that forces a new decision in phase B |
| req_n | input | 16 | Active-low request, one bit per client |
| gnt_n | output | 16 | Active-low registered grant, one bit per client |

## Verification
A corrupted owner register shows up at the grant pins on the very next phase-A edge. It appears either as the wrong bit low, or as a stuck low bit after the owner has released its request. A corrupted scan start shows nothing until the next contested decision. At that point the bench sees a different winner among several clients that are all requesting. For that reason the sweeps force decisions with many requests active, so that a pointer error reaches the pins within a few phase-B cycles.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;

    localparam int unsigned DEF_CLIENTS = 16;

    // Reason a phase-B cycle takes a new decision
    typedef enum logic [1:0] {
        CAUSE_KEEP     = 2'd0,
        CAUSE_FORCED   = 2'd1,
        CAUSE_RELEASED = 2'd2,
        CAUSE_IDLE_REQ = 2'd3
    } rearb_cause_e;

endpackage

// File: rtl/rr_scan.sv
module rr_scan #(
    parameter int unsigned N  = 16,
    parameter int unsigned PW = 4
) (
    input  logic [PW-1:0] start,
    input  logic [N-1:0]  req_n,
    output logic          hit,
    output logic [PW-1:0] win
);
    localparam logic [PW:0] NL = (PW+1)'(N);

    logic [PW:0] idx;

    always_comb begin
        hit = 1'b0;
        win = '0;
        idx = '0;
        for (int o = 0; o < N; o++) begin
            idx = {1'b0, start} + (PW+1)'(o);
            if (idx >= NL) idx = idx - NL;
            if (!hit && !req_n[idx[PW-1:0]]) begin
                hit = 1'b1;
                win = idx[PW-1:0];
            end
        end
    end
endmodule

// File: rtl/rr_state.sv
module rr_state
    import rr_arb_pkg::*;
#(
    parameter int unsigned N  = 16,
    parameter int unsigned PW = 4,
    parameter int unsigned HW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ph_b_en,
    input  logic          force_n,
    input  logic [N-1:0]  req_n,
    input  logic          hit,
    input  logic [PW-1:0] win,
    output logic [HW-1:0] holder_q,
    output logic [PW-1:0] start_q
);
    localparam logic [HW-1:0] NONE = HW'(N);
    localparam logic [PW-1:0] LAST = PW'(N-1);

    rearb_cause_e cause;
    logic         owned;

    always_comb begin
        owned = (holder_q < NONE);
        if (!force_n)
            cause = CAUSE_FORCED;
        else if (owned && req_n[holder_q[PW-1:0]])
            cause = CAUSE_RELEASED;
        else if (!owned && !(&req_n))
            cause = CAUSE_IDLE_REQ;
        else
            cause = CAUSE_KEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            holder_q <= NONE;
            start_q  <= '0;
        end else if (ph_b_en && cause != CAUSE_KEEP) begin
            if (hit) begin
                holder_q <= HW'(win);
                start_q  <= (win == LAST) ? '0 : win + 1'b1;
            end else begin
                holder_q <= NONE;
            end
        end
    end
endmodule

// File: rtl/rr_grant.sv
module rr_grant #(
    parameter int unsigned N  = 16,
    parameter int unsigned HW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ph_a_en,
    input  logic [HW-1:0] holder,
    output logic [N-1:0]  gnt_n
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                gnt_n[i] <= 1'b1;
            else if (ph_a_en)
                gnt_n[i] <= (holder != HW'(i));
        end
    end
endmodule

// File: rtl/rr16_arbiter.sv
module rr16_arbiter
    import rr_arb_pkg::*;
#(
    parameter int unsigned N = DEF_CLIENTS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ph_a_en,
    input  logic         ph_b_en,
    input  logic         force_n,
    input  logic [N-1:0] req_n,
    output logic [N-1:0] gnt_n
);
    localparam int unsigned PW = (N > 1) ? $clog2(N) : 1;
    localparam int unsigned HW = $clog2(N + 1);

    logic          hit;
    logic [PW-1:0] win;
    logic [HW-1:0] holder_q;
    logic [PW-1:0] start_q;

    rr_scan #(.N(N), .PW(PW)) u_scan (
        .start (start_q),
        .req_n (req_n),
        .hit   (hit),
        .win   (win)
    );

    rr_state #(.N(N), .PW(PW), .HW(HW)) u_state (
        .clk      (clk),
        .rst      (rst),
        .ph_b_en  (ph_b_en),
        .force_n  (force_n),
        .req_n    (req_n),
        .hit      (hit),
        .win      (win),
        .holder_q (holder_q),
        .start_q  (start_q)
    );

    rr_grant #(.N(N), .HW(HW)) u_grant (
        .clk     (clk),
        .rst     (rst),
        .ph_a_en (ph_a_en),
        .holder  (holder_q),
        .gnt_n   (gnt_n)
    );
endmodule

// File: rtl/rr16_arbiter_chk.sv
module rr16_arbiter_chk #(
    parameter int unsigned N  = 16,
    parameter int unsigned HW = 5,
    parameter int unsigned PW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          ph_a_en,
    input logic          ph_b_en,
    input logic          force_n,
    input logic [N-1:0]  req_n,
    input logic [N-1:0]  gnt_n,
    input logic [HW-1:0] holder,
    input logic [PW-1:0] start
);
    localparam logic [HW-1:0] NONE = HW'(N);
    localparam logic [HW-1:0] LASTH = HW'(N-1);

    // R3
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~gnt_n));

    // R2
    gnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ph_a_en |=> $stable(gnt_n));

    // R2
    idle_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_a_en && holder == NONE) |=> (&gnt_n));

    // R8
    state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ph_b_en |=> ($stable(holder) && $stable(start)));

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_b_en && force_n && holder < NONE && !req_n[holder[PW-1:0]]) |=> $stable(holder));

    // R7
    none_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_b_en && (&req_n)) |=> (holder == NONE));

    // R6
    start_after_win_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_b_en && !force_n && !(&req_n)) |=>
            ((holder == LASTH) ? (start == '0) : (HW'(start) == holder + HW'(1))));
endmodule

bind rr16_arbiter rr16_arbiter_chk #(.N(N), .HW(HW), .PW(PW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ph_a_en (ph_a_en),
    .ph_b_en (ph_b_en),
    .force_n (force_n),
    .req_n   (req_n),
    .gnt_n   (gnt_n),
    .holder  (holder_q),
    .start   (start_q)
);

// File: tb/sim_rr16_arbiter.sv
`timescale 1ns/1ps
module sim_rr16_arbiter;
    localparam int NC = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ph_a_en = 1'b0;
    logic          ph_b_en = 1'b0;
    logic          force_n = 1'b1;
    logic [NC-1:0] req_n = '1;
    logic [NC-1:0] gnt_n;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    int m_start;
    int m_holder;
    logic [NC-1:0] m_gnt;

    always #2 clk = ~clk;

    rr16_arbiter #(.N(NC)) u0 (
        .clk(clk), .rst(rst), .ph_a_en(ph_a_en), .ph_b_en(ph_b_en),
        .force_n(force_n), .req_n(req_n), .gnt_n(gnt_n)
    );

    task automatic chk(input string tag, input logic [NC-1:0] act, input logic [NC-1:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: gnt_n=%h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] decode(input int h);
        logic [NC-1:0] g = '1;
        if (h < NC) g[h] = 1'b0;
        return g;
    endfunction

    // Drive one cycle, update the reference model, compare after the edge
    task automatic step(input string tag, input bit a, input bit b, input bit f,
                        input logic [NC-1:0] r);
        bit rearb;
        @(negedge clk);
        ph_a_en = a; ph_b_en = b; force_n = f; req_n = r;
        if (a) m_gnt = decode(m_holder);
        if (b) begin
            rearb = !f || (m_holder < NC ? r[m_holder] : (r != '1));
            if (rearb) begin
                m_holder = NC;
                for (int o = 0; o < NC; o++) begin
                    int c = (m_start + o) % NC;
                    if (!r[c]) begin
                        m_holder = c;
                        m_start = (c + 1) % NC;
                        break;
                    end
                end
            end
        end
        @(posedge clk);
        #1;
        chk(tag, gnt_n, m_gnt);
        checks++;
        if (!$onehot0(~gnt_n)) begin
            bad++;
            $display("FAIL R3: gnt_n=%h expected at most one low bit", gnt_n);
        end
    endtask

    function automatic logic [NC-1:0] lowbits(input int a, input int b, input int c);
        logic [NC-1:0] v = '1;
        if (a >= 0) v[a] = 1'b0;
        if (b >= 0) v[b] = 1'b0;
        if (c >= 0) v[c] = 1'b0;
        return v;
    endfunction

    initial begin
        #800000;
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        m_start = 0; m_holder = NC; m_gnt = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", gnt_n, '1);

        // R1 first decision after reset, all requesting -> client 0
        step("R1", 1, 1, 1, '0);
        chk("R9", gnt_n, '1);
        step("R1", 1, 0, 1, '0);
        chk("R1", gnt_n, decode(0));

        // R7 everyone releases -> no owner
        step("R7", 0, 1, 1, '1);
        step("R7", 1, 0, 1, '1);
        chk("R7", gnt_n, '1);

        // R2 decision without phase A leaves outputs alone
        step("R2", 0, 1, 1, lowbits(9, -1, -1));
        chk("R2", gnt_n, '1);
        step("R5", 1, 0, 1, lowbits(9, -1, -1));
        chk("R5", gnt_n, decode(9));

        // R4 sticky while owner keeps requesting
        step("R4", 1, 1, 1, lowbits(9, 3, -1));
        step("R4", 1, 1, 1, lowbits(9, 3, -1));
        chk("R4", gnt_n, decode(9));

        // R4 force strobe re-arbitrates from start 10 -> 12
        step("R4", 0, 1, 0, lowbits(9, 3, 12));
        step("R5", 1, 0, 1, lowbits(9, 3, 12));
        chk("R5", gnt_n, decode(12));

        // R6 start is 13 after winning 12: 13 chosen over 3
        step("R6", 0, 1, 1, lowbits(3, 13, -1));
        step("R6", 1, 0, 1, lowbits(3, 13, -1));
        chk("R6", gnt_n, decode(13));

        // R9 both phases together show the old owner
        step("R9", 1, 1, 1, lowbits(3, -1, -1));
        chk("R9", gnt_n, decode(13));
        step("R9", 1, 0, 1, lowbits(3, -1, -1));
        chk("R9", gnt_n, decode(3));

        // R8 no phase B: requests and strobe ignored
        step("R8", 0, 0, 0, lowbits(5, 6, -1));
        step("R8", 0, 0, 1, '1);
        step("R8", 1, 0, 0, lowbits(7, -1, -1));
        chk("R8", gnt_n, decode(3));

        // R6 wrap: owner 15 -> start 0
        step("R6", 0, 1, 0, lowbits(15, -1, -1));
        step("R6", 0, 1, 0, lowbits(0, 15, -1));
        step("R6", 1, 0, 1, lowbits(0, 15, -1));
        chk("R6", gnt_n, decode(0));

        // R5 sweep: single requester on each client
        for (int i = 0; i < NC; i++) begin
            step("R5", 0, 1, 1, lowbits(i, -1, -1));
            step("R5", 1, 0, 1, lowbits(i, -1, -1));
            chk("R5", gnt_n, decode(i));
        end

        // R2 R4 R5 pseudo-random sweep of phases, strobe and requests
        lfsr = 32'hACE1_2468;
        for (int n = 0; n < 4000; n++) begin
            logic [NC-1:0] r;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            r = lfsr[15:0] | (lfsr[19] ? lfsr[31:16] : '0);
            step("R2", lfsr[20] | lfsr[24], lfsr[22] | lfsr[26], lfsr[23] | lfsr[27] | lfsr[28], r);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule